// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block keeps a small, fully associative set of recently used page mappings and turns a virtual address into a physical address in a single lookup. Pages are 1 KiB. The low 10 bits of the virtual address pass through unchanged. The upper bits form the virtual page number, which is compared against every stored entry at the same time. On a hit, the stored frame number is concatenated with the untranslated displacement. No adder is involved.

Each entry holds:
- a virtual page number,
- a frame number,
- three permission bits (read, write, execute),
- a valid bit,
- a referenced bit, which is set by any successful access,
- a modified (dirty) bit, which is set by a successful write.

A lookup that finds no valid mapping reports a missing-mapping fault. A lookup that finds a mapping without the needed permission reports a protection fault. The page-table walk sits outside this block. After a fault, the handler installs the mapping through the fill port. The fill port writes one of these entries, checked in this order:
1. the entry that already holds the same page, if there is one;
2. otherwise the lowest-numbered free entry;
3. otherwise an entry picked by a 16-bit pseudo-random shift register.

A flush input empties the whole buffer in one cycle.

The lookup result is registered and held in a four-state response machine:
- `RS_IDLE`: no response this cycle.
- `RS_HIT`: translated address is valid.
- `RS_MISS`: no valid mapping was found.
- `RS_PROT`: a mapping was found but it lacks the required permission.

The machine is re-evaluated every cycle:
- idle→idle and any→idle when no request is presented;
- any→`RS_MISS` on a request without a match;
- any→`RS_PROT` on a match lacking permission;
- any→`RS_HIT` on a permitted match.

Top module: `xlat_buffer`

## Requirements
- R1: A response (`rsp_valid`=1) appears exactly one cycle after each cycle with `req_valid`=1, and `rsp_valid` is 0 in every other cycle, including the first cycle after reset.
- R2: On a permitted match, `rsp_paddr` equals `{frame, req_vaddr[9:0]}`, with the frame in the upper bits, and both fault outputs are 0.
- R3: When no valid entry holds `req_vaddr[31:10]`, `rsp_miss`=1, `rsp_prot`=0 and `rsp_paddr`=0.
- R4: `req_kind` encodes 0 = read, 1 = write, 2 = execute and 3 = reserved. The permission field has bit 0 = read, bit 1 = write and bit 2 = execute. A match whose permission bit for the kind is clear gives `rsp_prot`=1, `rsp_miss`=0 and `rsp_paddr`=0. Kind 3 always gives a protection fault, and it changes no referenced or dirty bit.
- R5: On a hit, `rsp_was_ref` and `rsp_was_dirty` report the entry's bits as they were before this access. A permitted access sets the referenced bit, a permitted write also sets the dirty bit, and a fill clears both. Both outputs are 0 on a fault.
- R6: A fill uses a free entry whenever one exists, so up to the entry count of distinct pages all stay resident. An installed mapping is usable from the next cycle.
- R7: A fill whose page is already present replaces that entry in place. The new frame and permissions take effect, its referenced and dirty bits restart at 0, and no other mapping is lost.
- R8: A fill of a new page into a full buffer evicts exactly one existing mapping.
- R9: A flush clears every mapping in one cycle and takes priority over a fill in the same cycle.
- R10: A lookup in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Registered response present |
| rsp_paddr | output | 18 | Frame concatenated with displacement, 0 on fault |
| rsp_miss | output | 1 | No valid mapping found |
| rsp_prot | output | 1 | Mapping found but permission lacking |
| rsp_was_ref | output | 1 | Referenced bit before this hit |
| rsp_was_dirty | output | 1 | Dirty bit before this hit |
| fill_valid | input | 1 | Install strobe |
| fill_vpn | input | 22 | Virtual page to install |
| fill_pfn | input | 8 | Frame to install |
| fill_rights | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush | input | 1 | Invalidate all entries |

## Verification
Wrong state inside the block shows up at the ports within two cycles. A corrupted stored tag or valid bit turns the next lookup of that page into a miss. A wrong frame or lost displacement shows as a bad `rsp_paddr` on the following cycle. Stale referenced or dirty bits appear on the very next hit to the same page through `rsp_was_ref`/`rsp_was_dirty`. Victim-choice faults, such as overwriting a live entry while free ones remain or evicting two pages, surface as an extra miss when every installed page is swept afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HIT  = 2'd1,
        RS_MISS = 2'd2,
        RS_PROT = 2'd3
    } rsp_state_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int PERM_BITS = 3;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 22,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         valid_vec,
    input  logic [ENTRIES*VPN_W-1:0]   tag_flat,
    input  logic [VPN_W-1:0]           key,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tag_flat[g*VPN_W +: VPN_W] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

    // R7: in-place refill keeps each page in at most one entry
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] SEED = 16'hACE1;

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] rnd_full;
    logic [IDX_W-1:0]  free_idx;
    logic              free_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (advance) begin
            lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
        end
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        rnd_full   = lfsr_q % LFSR_W'(ENTRIES);
        victim_idx = free_any ? free_idx : rnd_full[IDX_W-1:0];
    end

    // R6: a free entry is always chosen while one exists
    p_victim_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&valid_vec)) |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 22,
    parameter int PFN_W   = 8,
    parameter int OFF_W   = 10,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PFN_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [VA_W-1:0]      req_vaddr,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic                 rsp_miss,
    output logic                 rsp_prot,
    output logic                 rsp_was_ref,
    output logic                 rsp_was_dirty,
    input  logic                 fill_valid,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PFN_W-1:0]     fill_pfn,
    input  logic [PERM_BITS-1:0] fill_rights,
    input  logic                 flush
);
    logic [ENTRIES*VPN_W-1:0]   tag_flat;
    logic [PFN_W-1:0]           pfn_q    [ENTRIES];
    logic [PERM_BITS-1:0]       rights_q [ENTRIES];
    logic [ENTRIES-1:0]         valid_q, ref_q, dirty_q;

    logic                       look_hit, fill_hit;
    logic [IDX_W-1:0]           look_idx, fill_hit_idx, victim_idx, fill_idx;
    logic                       allowed, look_ok, is_write;
    acc_kind_e                  kind;
    rsp_state_e                 state_q, state_d;
    logic [PA_W-1:0]            paddr_q;
    logic                       was_ref_q, was_dirty_q;

    assign kind = acc_kind_e'(req_kind);

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_look (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_q), .tag_flat(tag_flat),
        .key(req_vaddr[VA_W-1:OFF_W]), .hit(look_hit), .hit_idx(look_idx));

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fmatch (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_q), .tag_flat(tag_flat),
        .key(fill_vpn), .hit(fill_hit), .hit_idx(fill_hit_idx));

    xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .advance(fill_valid && !fill_hit && !flush),
        .valid_vec(valid_q), .victim_idx(victim_idx));

    assign fill_idx = fill_hit ? fill_hit_idx : victim_idx;

    // permission decode for the requested kind
    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = rights_q[look_idx][PERM_R];
            ACC_WRITE: allowed = rights_q[look_idx][PERM_W];
            ACC_EXEC:  allowed = rights_q[look_idx][PERM_X];
            ACC_RSVD:  allowed = 1'b0;
        endcase
    end

    assign is_write = (kind == ACC_WRITE);
    assign look_ok  = req_valid && look_hit && allowed;

    // next response state
    always_comb begin
        if (!req_valid)     state_d = RS_IDLE;
        else if (!look_hit) state_d = RS_MISS;
        else if (!allowed)  state_d = RS_PROT;
        else                state_d = RS_HIT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // registered response payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q     <= '0;
            was_ref_q   <= 1'b0;
            was_dirty_q <= 1'b0;
        end else if (state_d == RS_HIT) begin
            paddr_q     <= {pfn_q[look_idx], req_vaddr[OFF_W-1:0]};
            was_ref_q   <= ref_q[look_idx];
            was_dirty_q <= dirty_q[look_idx];
        end else begin
            paddr_q     <= '0;
            was_ref_q   <= 1'b0;
            was_dirty_q <= 1'b0;
        end
    end

    // outputs decoded from the response state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_miss  = 1'b0;
        rsp_prot  = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HIT:  rsp_valid = 1'b1;
            RS_MISS: begin rsp_valid = 1'b1; rsp_miss = 1'b1; end
            RS_PROT: begin rsp_valid = 1'b1; rsp_prot = 1'b1; end
        endcase
    end
    assign rsp_paddr     = paddr_q;
    assign rsp_was_ref   = was_ref_q;
    assign rsp_was_dirty = was_dirty_q;

    // entry status bits: flush over fill over access update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
            dirty_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
            ref_q   <= '0;
            dirty_q <= '0;
        end else begin
            if (look_ok) begin
                ref_q[look_idx] <= 1'b1;
                if (is_write) dirty_q[look_idx] <= 1'b1;
            end
            if (fill_valid) begin
                valid_q[fill_idx] <= 1'b1;
                ref_q[fill_idx]   <= 1'b0;
                dirty_q[fill_idx] <= 1'b0;
            end
        end
    end

    // entry payload
    always_ff @(posedge clk) begin
        if (fill_valid && !flush) begin
            tag_flat[fill_idx*VPN_W +: VPN_W] <= fill_vpn;
            pfn_q[fill_idx]                   <= fill_pfn;
            rights_q[fill_idx]                <= fill_rights;
        end
    end

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_hit_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!(rsp_valid && !rsp_miss && !rsp_prot) ||
                       rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
    p_dirty_has_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~ref_q) == '0);
    p_fill_installs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> valid_q[$past(fill_idx)]);
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid, rsp_miss, rsp_prot, rsp_was_ref, rsp_was_dirty;
    logic [17:0] rsp_paddr;
    logic        fill_valid = 1'b0;
    logic [21:0] fill_vpn = '0;
    logic [7:0]  fill_pfn = '0;
    logic [2:0]  fill_rights = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [21:0] m_vpn [N];
    logic [7:0]  m_pfn [N];
    logic [2:0]  m_rt  [N];
    bit          m_ref [N];
    bit          m_dty [N];

    always #5ns clk = ~clk;

    xlat_buffer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_miss(rsp_miss), .rsp_prot(rsp_prot), .rsp_was_ref(rsp_was_ref),
        .rsp_was_dirty(rsp_was_dirty), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_rights(fill_rights), .flush(flush));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [1:0] k, input logic [21:0] vpn, input logic [9:0] off);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_vaddr = {vpn, off};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [21:0] vpn, input logic [7:0] pfn, input logic [2:0] rt);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_rights = rt;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic expect_miss(input string req);
        chk(rsp_valid && rsp_miss && !rsp_prot && rsp_paddr == 0, req,
            {rsp_valid, rsp_miss, rsp_prot, rsp_paddr}, {3'b110, 18'h0});
    endtask

    // one access to model entry i with kind k, checked against the model
    task automatic access(input int i, input logic [1:0] k, input logic [9:0] off);
        bit ok;
        look(k, m_vpn[i], off);
        ok = (k != 2'd3) && m_rt[i][k];
        if (ok) begin
            chk(rsp_valid && !rsp_miss && !rsp_prot, "R2", {rsp_valid, rsp_miss, rsp_prot}, 3'b100);
            chk(rsp_paddr == {m_pfn[i], off}, "R2", rsp_paddr, {m_pfn[i], off});
            chk(rsp_was_ref == m_ref[i], "R5", rsp_was_ref, m_ref[i]);
            chk(rsp_was_dirty == m_dty[i], "R5", rsp_was_dirty, m_dty[i]);
            m_ref[i] = 1'b1;
            if (k == 2'd1) m_dty[i] = 1'b1;
        end else begin
            chk(rsp_valid && rsp_prot && !rsp_miss && rsp_paddr == 0, "R4",
                {rsp_valid, rsp_miss, rsp_prot, rsp_paddr}, {3'b101, 18'h0});
            chk(!rsp_was_ref && !rsp_was_dirty, "R5", {rsp_was_ref, rsp_was_dirty}, 0);
        end
    endtask

    function automatic int count_misses();
        return 0;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int misses;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rsp_valid && !rsp_miss && !rsp_prot, "R1", {rsp_valid, rsp_miss, rsp_prot}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R1", rsp_valid, 0);

        // R3 empty buffer misses
        look(2'd0, 22'd1234, 10'd5);
        expect_miss("R3");
        @(negedge clk);
        chk(!rsp_valid, "R1", rsp_valid, 0);

        // R6 fill every entry with distinct pages
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = 22'(100 + 7 * i);
            m_pfn[i] = 8'(3 * i + 1);
            m_rt[i]  = 3'(i % 8);
            m_ref[i] = 1'b0;
            m_dty[i] = 1'b0;
            fill(m_vpn[i], m_pfn[i], m_rt[i]);
        end

        // R2 R4 R5 sweep of every entry with every kind, two rounds
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < N; i++) begin
                for (int k = 0; k < 4; k++) begin
                    access(i, 2'(k), 10'((i * 37 + k * 101 + r * 511) % 1024));
                end
            end
        end

        // R3 unmapped page
        look(2'd0, 22'd99, 10'h3FF);
        expect_miss("R3");

        // R7 refill of an existing page in place
        m_pfn[0] = 8'd200; m_rt[0] = 3'b111; m_ref[0] = 1'b0; m_dty[0] = 1'b0;
        fill(m_vpn[0], m_pfn[0], m_rt[0]);
        access(0, 2'd1, 10'd77);
        chk(rsp_paddr == {8'd200, 10'd77}, "R7", rsp_paddr, {8'd200, 10'd77});
        misses = 0;
        for (int i = 0; i < N; i++) begin
            look(2'd3, m_vpn[i], 10'd0);
            if (rsp_miss) misses++;
        end
        chk(misses == 0, "R7", misses, 0);

        // R10 lookup alongside a fill of the same page sees old contents
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_vaddr = {22'd5000, 10'd9};
        fill_valid = 1'b1; fill_vpn = 22'd5000; fill_pfn = 8'd77; fill_rights = 3'b001;
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0;
        expect_miss("R10");
        look(2'd0, 22'd5000, 10'd9);
        chk(rsp_valid && !rsp_miss && rsp_paddr == {8'd77, 10'd9}, "R10",
            rsp_paddr, {8'd77, 10'd9});

        // R8 exactly one old mapping was evicted by that fill into a full buffer
        misses = 0;
        for (int i = 0; i < N; i++) begin
            look(2'd3, m_vpn[i], 10'd0);
            if (rsp_miss) misses++;
        end
        chk(misses == 1, "R8", misses, 1);

        // R9 flush empties all
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        misses = 0;
        for (int i = 0; i < N; i++) begin
            look(2'd0, m_vpn[i], 10'd1);
            if (rsp_miss) misses++;
        end
        look(2'd0, 22'd5000, 10'd1);
        if (rsp_miss) misses++;
        chk(misses == N + 1, "R9", misses, N + 1);

        // R9 flush wins over a simultaneous fill
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = 22'd42; fill_pfn = 8'd5; fill_rights = 3'b111;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        look(2'd0, 22'd42, 10'd3);
        expect_miss("R9");

        // R6 install after flush usable next cycle
        fill(22'd42, 8'd6, 3'b100);
        look(2'd2, 22'd42, 10'd3);
        chk(rsp_valid && !rsp_miss && !rsp_prot && rsp_paddr == {8'd6, 10'd3}, "R6",
            rsp_paddr, {8'd6, 10'd3});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule